// File: doc/BRIEF.md
# Zero-Operand Stack Arithmetic Unit

This block evaluates arithmetic expressions in hardware using a last-in first-out operand stack and instructions that name no operands. A command carries an opcode and a data word and is accepted over a valid/ready handshake. A push places the data word on top of the stack. A pop removes the top entry and returns it on a strobed output. The four arithmetic commands each take the two topmost entries and leave a single result in their place.

For the order-sensitive operations, the entry just below the top is the left operand and the top entry is the right operand. Entries are 16-bit two's-complement values and the stack holds eight of them. Multiplication completes in the cycle it is accepted. Division runs as a bit-serial loop, one quotient bit per cycle, and holds ready low until its result is on the stack. A command that cannot run leaves the stack unchanged and raises a one-cycle error pulse: too few entries, a push onto a full stack, or a zero divisor.

Top module: `stack_calc`

## Requirements
- R1: A push accepted while fewer than 8 entries are held places `cmd_data` on top and raises `depth` by one in the next cycle. Entries come back out in last-in first-out order.
- R2: A pop accepted with at least one entry held pulses `pop_valid` for one cycle with the former top in `pop_data`, and lowers `depth` by one.
- R3: ADD (opcode 2) and SUB (opcode 3) replace the top two entries with next+top and next-top, and lower `depth` by one. Here next is the entry below the top.
- R4: MUL (opcode 4) replaces the top two entries with the low 16 bits of their product, and lowers `depth` by one.
- R5: DIV (opcode 5) replaces the top two entries with next/top truncated toward zero, and lowers `depth` by one. -32768/-1 wraps to -32768 (0x8000).
- R6: A pop on an empty stack, or an arithmetic opcode with fewer than two entries, pulses `err_underflow` for one cycle and leaves the stack and `depth` unchanged.
- R7: A push (opcode 0) while 8 entries are held pulses `err_overflow` for one cycle and is ignored. `depth` never exceeds 8.
- R8: DIV with a zero top entry pulses `err_divzero` for one cycle, leaves both operands in place, and pushes nothing.
- R9: A command is accepted only in a cycle where `cmd_valid` and `cmd_ready` are both high. After an accepted DIV that will divide, `cmd_ready` is low in the next cycle and stays low until the quotient has been written.
- R10: Opcodes 6 and 7 are accepted but change neither the stack nor any output.
- R11: After reset, `depth` is 0, `tos` is 0, `cmd_ready` is 1, and `pop_valid` and all error flags are 0. An empty stack shows `tos` as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | The block can take a command this cycle |
| cmd_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5 div |
| cmd_data | input | 16 | Value for a push |
| tos | output | 16 | Current top entry, 0 when empty |
| depth | output | 4 | Number of entries held |
| pop_valid | output | 1 | One-cycle strobe for a completed pop |
| pop_data | output | 16 | Value removed by the last pop |
| err_underflow | output | 1 | Too few entries for the last command |
| err_overflow | output | 1 | Push onto a full stack |
| err_divzero | output | 1 | Division by a zero top entry |

## Verification
Some properties hold on every cycle and are checked by the assertions. Depth stays within the stack size. A push moves the data word to the top and adds one entry. A pop strobe always matches one entry removed. Each error pulse leaves the depth where it was, and ready drops after a division that will run. The pulses never coincide. The arithmetic results cannot be checked that way. These are operand order, low-half product wrap, truncation of negative quotients, the -32768/-1 wrap, and the order in which a full stack empties. The bench's scenarios show them by comparing against values worked out by hand.

// File: rtl/stack_calc.sv
module stack_calc #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [2:0]                   cmd_op,
  input  logic [WIDTH-1:0]             cmd_data,
  output logic [WIDTH-1:0]             tos,
  output logic [$clog2(DEPTH):0]       depth,
  output logic                         pop_valid,
  output logic [WIDTH-1:0]             pop_data,
  output logic                         err_underflow,
  output logic                         err_overflow,
  output logic                         err_divzero
);
  localparam int AW = $clog2(DEPTH);
  localparam int DW = AW + 1;
  localparam int SW = $clog2(WIDTH);
  localparam logic [DW-1:0] FULL = DW'(DEPTH);
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_ADD = 3'd2,
                         OP_SUB = 3'd3, OP_MUL = 3'd4, OP_DIV = 3'd5;

  logic [WIDTH-1:0] stk [DEPTH];
  logic [DW-1:0]    cnt_q;
  logic [AW-1:0]    idx_top, idx_nxt;
  logic [WIDTH-1:0] a_v, b_v, alu_v;
  logic             has1, has2, full, acc;

  logic             busy_q, neg_q;
  logic [SW-1:0]    step_q;
  logic [WIDTH-1:0] rem_q, quo_q, den_q;
  logic [WIDTH:0]   rem_sh;
  logic             ge;
  logic [WIDTH-1:0] rem_nx, quo_nx, div_res;

  logic             wr_en;
  logic [AW-1:0]    wr_idx;
  logic [WIDTH-1:0] wr_val;

  function automatic logic [WIDTH-1:0] mag(input logic [WIDTH-1:0] x);
    return x[WIDTH-1] ? (~x + 1'b1) : x;
  endfunction

  assign idx_top   = cnt_q[AW-1:0] - 1'b1;
  assign idx_nxt   = cnt_q[AW-1:0] - 2'd2;
  assign a_v       = stk[idx_nxt];
  assign b_v       = stk[idx_top];
  assign has1      = cnt_q != '0;
  assign has2      = cnt_q >= DW'(2);
  assign full      = cnt_q == FULL;
  assign cmd_ready = !busy_q;
  assign acc       = cmd_valid && cmd_ready;
  assign tos       = has1 ? b_v : '0;
  assign depth     = cnt_q;

  always_comb begin
    case (cmd_op)
      OP_ADD:  alu_v = a_v + b_v;
      OP_SUB:  alu_v = a_v - b_v;
      default: alu_v = a_v * b_v;
    endcase
  end

  assign rem_sh  = {rem_q, quo_q[WIDTH-1]};
  assign ge      = rem_sh >= {1'b0, den_q};
  assign rem_nx  = ge ? WIDTH'(rem_sh - {1'b0, den_q}) : rem_sh[WIDTH-1:0];
  assign quo_nx  = {quo_q[WIDTH-2:0], ge};
  assign div_res = neg_q ? (~quo_nx + 1'b1) : quo_nx;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = idx_nxt;
    wr_val = alu_v;
    if (busy_q) begin
      wr_en  = step_q == SW'(WIDTH - 1);
      wr_val = div_res;
    end else if (acc) begin
      if (cmd_op == OP_PUSH && !full) begin
        wr_en  = 1'b1;
        wr_idx = cnt_q[AW-1:0];
        wr_val = cmd_data;
      end else if ((cmd_op == OP_ADD || cmd_op == OP_SUB || cmd_op == OP_MUL) && has2) begin
        wr_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) stk[wr_idx] <= wr_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q         <= '0;
      busy_q        <= 1'b0;
      neg_q         <= 1'b0;
      step_q        <= '0;
      rem_q         <= '0;
      quo_q         <= '0;
      den_q         <= '0;
      pop_valid     <= 1'b0;
      pop_data      <= '0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
      err_divzero   <= 1'b0;
    end else begin
      pop_valid     <= 1'b0;
      err_underflow <= 1'b0;
      err_overflow  <= 1'b0;
      err_divzero   <= 1'b0;
      if (busy_q) begin
        rem_q  <= rem_nx;
        quo_q  <= quo_nx;
        step_q <= step_q + 1'b1;
        if (step_q == SW'(WIDTH - 1)) begin
          busy_q <= 1'b0;
          cnt_q  <= cnt_q - 1'b1;
        end
      end else if (acc) begin
        case (cmd_op)
          OP_PUSH: begin
            if (full) err_overflow <= 1'b1;
            else      cnt_q <= cnt_q + 1'b1;
          end
          OP_POP: begin
            if (!has1) err_underflow <= 1'b1;
            else begin
              pop_valid <= 1'b1;
              pop_data  <= b_v;
              cnt_q     <= cnt_q - 1'b1;
            end
          end
          OP_ADD, OP_SUB, OP_MUL: begin
            if (!has2) err_underflow <= 1'b1;
            else       cnt_q <= cnt_q - 1'b1;
          end
          OP_DIV: begin
            if (!has2)            err_underflow <= 1'b1;
            else if (b_v == '0)   err_divzero   <= 1'b1;
            else begin
              busy_q <= 1'b1;
              step_q <= '0;
              rem_q  <= '0;
              quo_q  <= mag(a_v);
              den_q  <= mag(b_v);
              neg_q  <= a_v[WIDTH-1] ^ b_v[WIDTH-1];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/stack_calc_chk.sv
module stack_calc_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic [2:0]             cmd_op,
  input logic [WIDTH-1:0]       cmd_data,
  input logic [WIDTH-1:0]       tos,
  input logic [$clog2(DEPTH):0] depth,
  input logic                   pop_valid,
  input logic                   err_underflow,
  input logic                   err_overflow,
  input logic                   err_divzero
);
  localparam int DW = $clog2(DEPTH) + 1;
  localparam logic [DW-1:0] FULL = DW'(DEPTH);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_depth_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= FULL);

  p_push_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd0 && depth != FULL) |=>
      (depth == $past(depth) + 1'b1) && (tos == $past(cmd_data)));

  p_pop_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> depth == $past(depth) - 1'b1);

  p_underflow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |-> $stable(depth));

  p_overflow_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |-> (depth == FULL) && $stable(depth));

  p_divzero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_divzero |-> $stable(depth) && (tos == '0));

  p_div_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 3'd5 && depth >= DW'(2) && tos != '0) |=> !cmd_ready);

  p_pulse_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_valid, err_underflow, err_overflow, err_divzero}));
endmodule

bind stack_calc stack_calc_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .tos(tos), .depth(depth),
  .pop_valid(pop_valid), .err_underflow(err_underflow),
  .err_overflow(err_overflow), .err_divzero(err_divzero)
);

// File: tb/stack_calc_tb.sv
module stack_calc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_data = '0;
  logic [15:0] tos, pop_data;
  logic [3:0]  depth;
  logic        pop_valid, err_underflow, err_overflow, err_divzero;

  int checks = 0;
  int errors = 0;
  logic c_pv, c_uf, c_of, c_dz, c_busy;
  logic [15:0] c_pd;

  stack_calc u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .tos(tos), .depth(depth),
    .pop_valid(pop_valid), .pop_data(pop_data), .err_underflow(err_underflow),
    .err_overflow(err_overflow), .err_divzero(err_divzero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] data;
    logic [15:0] tos;
    logic [3:0]  dep;
    logic        pv;
    logic [15:0] pd;
    logic        uf;
    logic        dz;
  } vec_t;

  localparam vec_t VEC [22] = '{
    '{3'd0, 16'h0007, 16'h0007, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd0, 16'h0003, 16'h0003, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd3, 16'h0000, 16'h0004, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd0, 16'h000A, 16'h000A, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd4, 16'h0000, 16'h0028, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd0, 16'hFFFA, 16'hFFFA, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd2, 16'h0000, 16'h0022, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd0, 16'h0005, 16'h0005, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd5, 16'h0000, 16'h0006, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd0, 16'hFFFC, 16'hFFFC, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd5, 16'h0000, 16'hFFFF, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd1, 16'h0000, 16'h0000, 4'd0, 1'b1, 16'hFFFF, 1'b0, 1'b0},
    '{3'd1, 16'h0000, 16'h0000, 4'd0, 1'b0, 16'h0000, 1'b1, 1'b0},
    '{3'd0, 16'h0009, 16'h0009, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd2, 16'h0000, 16'h0009, 4'd1, 1'b0, 16'h0000, 1'b1, 1'b0},
    '{3'd0, 16'h0000, 16'h0000, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd5, 16'h0000, 16'h0000, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b1},
    '{3'd1, 16'h0000, 16'h0009, 4'd1, 1'b1, 16'h0000, 1'b0, 1'b0},
    '{3'd0, 16'hFFF9, 16'hFFF9, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd0, 16'h0002, 16'h0002, 4'd3, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd5, 16'h0000, 16'hFFFD, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0},
    '{3'd3, 16'h0000, 16'h000C, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0:       return "R1";
      3'd1:       return "R2";
      3'd2, 3'd3: return "R3";
      3'd4:       return "R4";
      default:    return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] data);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_data = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    c_pv = pop_valid; c_pd = pop_data; c_uf = err_underflow;
    c_of = err_overflow; c_dz = err_divzero; c_busy = !cmd_ready;
    while (!cmd_ready) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(depth == 0 && tos == 0, "R11", "reset depth/tos", {depth, tos}, 0);
    check(cmd_ready && !pop_valid && !err_underflow && !err_overflow && !err_divzero,
          "R11", "reset ready/flags", {cmd_ready, pop_valid, err_underflow, err_overflow, err_divzero}, 5'b10000);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      issue(VEC[i].op, VEC[i].data);
      check(tos == VEC[i].tos, tag_of(VEC[i].op), $sformatf("vec %0d tos", i), tos, VEC[i].tos);
      check(depth == VEC[i].dep, tag_of(VEC[i].op), $sformatf("vec %0d depth", i), depth, VEC[i].dep);
      check(c_pv == VEC[i].pv, "R2", $sformatf("vec %0d pop_valid", i), c_pv, VEC[i].pv);
      if (VEC[i].pv)
        check(c_pd == VEC[i].pd, "R2", $sformatf("vec %0d pop_data", i), c_pd, VEC[i].pd);
      check(c_uf == VEC[i].uf, "R6", $sformatf("vec %0d underflow", i), c_uf, VEC[i].uf);
      check(c_dz == VEC[i].dz, "R8", $sformatf("vec %0d divzero", i), c_dz, VEC[i].dz);
    end

    issue(3'd6, 16'h1234);
    check(tos == 16'h000C && depth == 1, "R10", "opcode 6 ignored", {depth, tos}, {4'd1, 16'h000C});
    check(!c_pv && !c_uf && !c_of && !c_dz, "R10", "opcode 6 no pulse", {c_pv, c_uf, c_of, c_dz}, 0);
    issue(3'd7, 16'h5678);
    check(tos == 16'h000C && depth == 1, "R10", "opcode 7 ignored", {depth, tos}, {4'd1, 16'h000C});

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check(depth == 0 && tos == 0 && cmd_ready, "R11", "mid-run reset", {cmd_ready, depth, tos}, {1'b1, 20'h0});

    for (int k = 1; k <= 8; k++) issue(3'd0, 16'(k));
    check(depth == 8 && tos == 16'd8, "R1", "fill to 8", {depth, tos}, {4'd8, 16'd8});
    issue(3'd0, 16'd99);
    check(c_of == 1'b1, "R7", "overflow pulse", c_of, 1);
    check(depth == 8 && tos == 16'd8, "R7", "overflow push ignored", {depth, tos}, {4'd8, 16'd8});
    for (int k = 8; k >= 1; k--) begin
      issue(3'd1, 16'h0);
      check(c_pv && c_pd == 16'(k), "R1", "LIFO pop order", c_pd, k);
    end
    check(depth == 0, "R2", "empty after pops", depth, 0);

    issue(3'd0, 16'd300);
    issue(3'd0, 16'd300);
    issue(3'd4, 16'h0);
    check(tos == 16'h5F90 && depth == 1, "R4", "mul low half", tos, 16'h5F90);

    issue(3'd0, 16'h8000);
    issue(3'd0, 16'hFFFF);
    issue(3'd5, 16'h0);
    check(c_busy == 1'b1, "R9", "ready low during div", c_busy, 1);
    check(tos == 16'h8000 && depth == 2, "R5", "-32768/-1 wrap", {depth, tos}, {4'd2, 16'h8000});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule